// File: doc/BRIEF.md
# FSK Carrier Presence Qualifier

This block decides whether a frequency-shift-keyed carrier is really on the line. An upstream detector supplies a single-cycle strobe each time the band-pass filter output shows enough energy. The qualifier looks only at when those strobes arrive. The carrier flag is asserted only after the strobes have kept coming for a programmable qualification time, with no gap longer than about one bit time. Once asserted, the flag rides through dropouts and is released only after a fixed quiet interval in which no strobe arrives at all.

The block has two outputs that carry the same decision. `cd_n` is the active-low carrier flag. `carrier_ok` is the active-high enable for the framing logic that follows, so demodulated bits are held back whenever no carrier has been qualified. All time spans are counted in milliseconds, using a tick divided down from the system clock. A power-down input drops the flag at once and clears every timer. The amplitude measurement and the filtering stay with the upstream logic.

Top module: `fsk_carrier_qualifier`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a rising edge) `cd_n` is 1 and `carrier_ok` is 0, and both stay so until a qualification completes.
- R2: From idle, a strobe sampled at edge E starts qualification. If no gap in R3 interrupts it, `cd_n` goes low, and `carrier_ok` goes high, after edge E + QUAL_MS*CYC_PER_MS and not earlier.
- R3: During qualification, a strobe may arrive up to BIT_CYCLES+1 edges after the previous one. If BIT_CYCLES+1 consecutive edges pass without a strobe, qualification is abandoned. The next strobe then starts the full qualification time again.
- R4: Once the carrier is detected, any quiet spell shorter than the release time, even one much longer than a bit, leaves `cd_n` low.
- R5: While detected, each strobe restarts the release timer. `cd_n` returns to 1 at edge L + REL_MS*CYC_PER_MS, where L is the last strobe edge or the edge where detection began, whichever is later.
- R6: `carrier_ok` is always the inverse of `cd_n`.
- R7: While `pwr_dn` is 1, `cd_n` is 1 in the same cycle and strobes are ignored. After `pwr_dn` returns to 0, detection needs a fresh full qualification.
- R8: The controller is always in exactly one of three states: idle, qualifying or detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| act_stb | input | 1 | One-cycle strobe: filter output shows activity |
| pwr_dn | input | 1 | Power-down, active high; forces carrier inactive and clears state |
| cd_n | output | 1 | Carrier detect, active low |
| carrier_ok | output | 1 | Carrier-valid enable for the framing logic, active high |

## Verification
The bench measures the edge at which detection begins and the edge at which it ends, down to the exact cycle. A timer that is off by one millisecond tick, or one that starts before the first strobe, shows up as a flag that moves early or late. Gaps of BIT_CYCLES and BIT_CYCLES+1 empty edges are driven on either side of the limit: a comparison that is off by one would either drop a valid carrier or accept a broken one. A quiet spell far longer than a bit but shorter than the release time catches a design that reuses the qualification gap rule after detection. Power-down is driven with strobes present, and a fresh full-length qualification is required afterwards, to catch state that survives power-down.

// File: rtl/fcq_pkg.sv
// Package: shared types for the FSK carrier qualifier.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package fcq_pkg;

    // One-hot state encoding so legality can be checked with a single onehot test.
    typedef enum logic [2:0] {
        ST_IDLE = 3'b001,
        ST_QUAL = 3'b010,
        ST_DET  = 3'b100
    } fcq_state_t;

endpackage

// File: rtl/fcq_tick_div.sv
// Millisecond tick divider.
// Produces a one-cycle tick every DIV clocks. A clear input restarts the phase
// so that the next tick comes exactly DIV cycles after the clearing edge.
// Assumes DIV >= 2.
module fcq_tick_div #(
    parameter int DIV = 3580
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] phase;

    // Tick when the phase counter reaches its final value.
    always_comb tick = (phase == LAST);

    // Advance the phase, wrapping on tick and restarting on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) phase <= '0;
        else                       phase <= phase + 1'b1;
    end
endmodule

// File: rtl/fcq_gap_mon.sv
// Activity gap monitor.
// Counts edges since the last activity strobe, saturating at LIMIT.
// gap_long is high once LIMIT edges have passed with no strobe.
// Assumes LIMIT >= 1.
module fcq_gap_mon #(
    parameter int LIMIT = 2983
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic stb,
    output logic gap_long
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] SAT = W'(LIMIT);

    logic [W-1:0] since;

    // Flag saturation of the quiet counter.
    always_comb gap_long = (since == SAT);

    // Restart on strobe or clear, otherwise count up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || stb) since <= '0;
        else if (since != SAT)    since <= since + 1'b1;
    end
endmodule

// File: rtl/fcq_ms_count.sv
// Millisecond counter shared by the qualify and release timers.
// Counts ticks, saturating at MAX. Clear has priority over counting.
// Assumes MAX >= 1.
module fcq_ms_count #(
    parameter int MAX = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       tick,
    output logic [$clog2(MAX+1)-1:0]   count
);
    localparam int W = $clog2(MAX + 1);
    localparam logic [W-1:0] TOP = W'(MAX);

    // Count ticks, clear on request, hold at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)             count <= '0;
        else if (tick && count != TOP) count <= count + 1'b1;
    end
endmodule

// File: rtl/fcq_fsm.sv
// Qualification state machine.
// Idle -> qualifying on a strobe; qualifying -> detected after QUAL_MS ticks
// with no long gap; detected -> idle after REL_MS ticks with no strobe.
// Drives the clears of the tick divider and the millisecond counter.
// Assumes QUAL_MS >= 1 and REL_MS >= 1.
module fcq_fsm
    import fcq_pkg::*;
#(
    parameter int QUAL_MS = 8,
    parameter int REL_MS  = 10,
    parameter int CW      = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stb,
    input  logic            pwr_dn,
    input  logic            tick,
    input  logic            gap_long,
    input  logic [CW-1:0]   ms_cnt,
    output fcq_state_t      state,
    output logic            div_clr,
    output logic            ms_clr
);
    localparam logic [CW-1:0] QUAL_LAST = CW'(QUAL_MS - 1);
    localparam logic [CW-1:0] REL_LAST  = CW'(REL_MS - 1);

    fcq_state_t nxt;
    logic       qual_done;
    logic       rel_done;

    // Timer end conditions, each fires on the tick that completes its span.
    always_comb begin
        qual_done = tick && (ms_cnt == QUAL_LAST);
        rel_done  = tick && (ms_cnt == REL_LAST);
    end

    // Next-state decision, power-down first.
    always_comb begin
        nxt = state;
        if (pwr_dn) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (stb) nxt = ST_QUAL;
                ST_QUAL: begin
                    if (gap_long && !stb) nxt = ST_IDLE;
                    else if (qual_done)   nxt = ST_DET;
                end
                ST_DET:  if (!stb && rel_done) nxt = ST_IDLE;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // Timer restarts: phase on each start or reload, count whenever idle or reloaded.
    always_comb begin
        div_clr = pwr_dn
               || (state == ST_IDLE && stb)
               || (state == ST_DET  && stb);
        ms_clr  = pwr_dn
               || (state == ST_IDLE)
               || (state == ST_QUAL && nxt != ST_QUAL)
               || (state == ST_DET  && stb);
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end
endmodule

// File: rtl/fsk_carrier_qualifier.sv
// FSK carrier qualifier, top level.
// Turns a per-sample activity strobe into a debounced carrier flag: it is
// asserted after sustained activity and released after a quiet interval.
// Assumes act_stb is synchronous to clk and one cycle wide per event.
module fsk_carrier_qualifier
    import fcq_pkg::*;
#(
    parameter int CYC_PER_MS = 3580,
    parameter int QUAL_MS    = 8,
    parameter int REL_MS     = 10,
    parameter int BIT_CYCLES = 2983
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_stb,
    input  logic pwr_dn,
    output logic cd_n,
    output logic carrier_ok
);
    localparam int MS_MAX = (QUAL_MS > REL_MS) ? QUAL_MS : REL_MS;
    localparam int CW     = $clog2(MS_MAX + 1);

    logic          tick;
    logic          gap_long;
    logic          div_clr;
    logic          ms_clr;
    logic [CW-1:0] ms_cnt;
    logic          stb_live;
    fcq_state_t    state;

    // Strobes are ignored while powered down.
    always_comb stb_live = act_stb && !pwr_dn;

    fcq_tick_div #(.DIV(CYC_PER_MS)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (div_clr),
        .tick  (tick)
    );

    fcq_gap_mon #(.LIMIT(BIT_CYCLES)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pwr_dn),
        .stb      (stb_live),
        .gap_long (gap_long)
    );

    fcq_ms_count #(.MAX(MS_MAX)) u_ms (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ms_clr),
        .tick  (tick),
        .count (ms_cnt)
    );

    fcq_fsm #(.QUAL_MS(QUAL_MS), .REL_MS(REL_MS), .CW(CW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (stb_live),
        .pwr_dn   (pwr_dn),
        .tick     (tick),
        .gap_long (gap_long),
        .ms_cnt   (ms_cnt),
        .state    (state),
        .div_clr  (div_clr),
        .ms_clr   (ms_clr)
    );

    // Output flags: power-down forces the inactive level at once.
    always_comb begin
        cd_n       = pwr_dn || (state != ST_DET);
        carrier_ok = !cd_n;
    end
endmodule

// File: rtl/fcq_checker.sv
// Checker for the FSK carrier qualifier: temporal properties on the
// controller state and its timer inputs. Attached by bind below.
module fcq_checker
    import fcq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       act_stb,
    input logic       pwr_dn,
    input logic       carrier_ok,
    input logic       tick,
    input logic       gap_long,
    input fcq_state_t state
);
    // R8: exactly one state active.
    p_onehot_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state));

    // R2: detection only follows qualification.
    p_detect_from_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier_ok) |-> $past(state) == ST_QUAL);

    // R3: a long gap without a strobe abandons qualification.
    p_gap_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUAL && gap_long && !act_stb && !pwr_dn) |=> state == ST_IDLE);

    // R4: a strobe while detected keeps the carrier.
    p_strobe_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DET && act_stb && !pwr_dn) |=> state == ST_DET);

    // R5: release only happens on a millisecond tick.
    p_release_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DET && !tick && !pwr_dn) |=> state == ST_DET);

    // R7: power-down returns the controller to idle.
    p_pwrdn_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> state == ST_IDLE);
endmodule

bind fsk_carrier_qualifier fcq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_stb    (act_stb),
    .pwr_dn     (pwr_dn),
    .carrier_ok (carrier_ok),
    .tick       (tick),
    .gap_long   (gap_long),
    .state      (state)
);

// File: tb/sim_fsk_carrier_qualifier.sv
// Directed bench for the FSK carrier qualifier, one task per scenario.
module sim_fsk_carrier_qualifier;
    localparam int DIV  = 20;
    localparam int QMS  = 8;
    localparam int RMS  = 10;
    localparam int BITC = 12;
    localparam int QCYC = QMS * DIV;   // 160
    localparam int RCYC = RMS * DIV;   // 200

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic act_stb = 1'b0;
    logic pwr_dn = 1'b0;
    logic cd_n;
    logic carrier_ok;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fsk_carrier_qualifier #(
        .CYC_PER_MS (DIV),
        .QUAL_MS    (QMS),
        .REL_MS     (RMS),
        .BIT_CYCLES (BITC)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_stb    (act_stb),
        .pwr_dn     (pwr_dn),
        .cd_n       (cd_n),
        .carrier_ok (carrier_ok)
    );

    // Compare both flags against the expected carrier level (R6 always).
    task automatic chk(input logic exp_cd_n, input string tag);
        checks++;
        if (cd_n !== exp_cd_n || carrier_ok !== !exp_cd_n) begin
            errors++;
            $display("FAIL %s: cd_n=%b carrier_ok=%b expected cd_n=%b carrier_ok=%b",
                     tag, cd_n, carrier_ok, exp_cd_n, !exp_cd_n);
        end
    endtask

    // Present a strobe value for the next rising edge, then move to the negedge after it.
    task automatic step(input logic s);
        act_stb = s;
        @(negedge clk);
        act_stb = 1'b0;
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) step(1'b0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(1'b1, "R1 reset level");
        rst_n = 1'b1;
        quiet(5);
        chk(1'b1, "R1 no strobe stays idle");
    endtask

    // Strobes every 4 edges; detection exactly QCYC edges after the first.
    task automatic t_qualify;
        for (int i = 0; i <= QCYC + 4; i++) begin
            step(i % 4 == 0);
            if (i == QCYC - 1) chk(1'b1, "R2 not before qualify time");
            if (i == QCYC)     chk(1'b0, "R2 asserted at qualify time");
        end
    endtask

    // Long dropout held, then release exactly RCYC after the last strobe.
    task automatic t_hold_release;
        step(1'b1);
        quiet(150);
        chk(1'b0, "R4 held through 150-cycle dropout");
        step(1'b1);                    // reload: edge L
        for (int j = 1; j <= RCYC; j++) begin
            step(1'b0);
            if (j == RCYC - 1) chk(1'b0, "R5 still held before release");
            if (j == RCYC)     chk(1'b1, "R5 released at release time");
        end
        quiet(20);
        chk(1'b1, "R5 stays released");
    endtask

    // Gap of BITC empty edges is tolerated during qualification.
    task automatic t_gap_ok;
        for (int i = 0; i <= QCYC; i++) begin
            logic s;
            s = (i <= 80 && i % 4 == 0) || (i >= 93 && (i - 93) % 4 == 0);
            step(s);
            if (i == QCYC - 1) chk(1'b1, "R3 tolerated gap, not early");
            if (i == QCYC)     chk(1'b0, "R3 tolerated gap, asserted on time");
        end
        quiet(RCYC + 5);
        chk(1'b1, "R5 released after gap test");
    endtask

    // Gap of BITC+1 empty edges restarts qualification at the next strobe.
    task automatic t_gap_restart;
        for (int i = 0; i <= 94 + QCYC; i++) begin
            logic s;
            s = (i <= 80 && i % 4 == 0) || (i >= 94 && (i - 94) % 4 == 0);
            step(s);
            if (i == QCYC)          chk(1'b1, "R3 long gap blocks first attempt");
            if (i == 94 + QCYC - 1) chk(1'b1, "R3 restart not early");
            if (i == 94 + QCYC)     chk(1'b0, "R3 restart asserted on time");
        end
    endtask

    // Power-down forces inactive, ignores strobes, requires full requalification.
    task automatic t_powerdown;
        chk(1'b0, "R7 detected before power-down");
        pwr_dn = 1'b1;
        #1;
        chk(1'b1, "R7 immediate inactive on power-down");
        for (int i = 0; i < 20; i++) step(i % 4 == 0);
        chk(1'b1, "R7 strobes ignored in power-down");
        pwr_dn = 1'b0;
        quiet(30);
        chk(1'b1, "R7 idle after power-down");
        for (int i = 0; i <= QCYC; i++) begin
            step(i % 4 == 0);
            if (i == QCYC - 1) chk(1'b1, "R7 fresh qualify not early");
            if (i == QCYC)     chk(1'b0, "R7 fresh qualify completes");
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_qualify();
        t_hold_release();
        t_gap_ok();
        t_gap_restart();
        t_powerdown();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule